// File: doc/BRIEF.md
# Four-Input Accumulating Averager

This block adds four small unsigned operands into a running total on each of four consecutive clock cycles after reset. It then presents the total divided by sixteen as a narrow average. Each cycle, the four inputs and the current total make five operands. A chain of carry-save stages reduces these five operands to a sum vector and a carry vector, and one carry-propagate add resolves the pair into the next total.

A synchronous reset starts a run. The block accumulates on the next four active edges and raises a one-cycle completion flag. It then freezes the total and ignores its inputs until the next reset. The largest reachable total is 4 × 4 × 15 = 240, so the 8-bit total never wraps.

Top module: `accum_averager`

## Requirements
- R1: A clock edge with `rst` high clears `sumOut` to 0 and `doneOut` to 0. Reset takes priority over any accumulation in the same cycle.
- R2: On each of the first four edges after reset with `rst` low, `sumOut` becomes its previous value plus `opA + opB + opC + opD`, with every input read as unsigned.
- R3: From the fifth edge after reset onward, `sumOut` holds its value and input changes have no effect, until the next reset.
- R4: `doneOut` is high for exactly one cycle. It goes high on the fourth accumulating edge, is low in every other cycle, and stays low after completion until a new run ends.
- R5: `avgOut` always equals bits 7 down to 4 of `sumOut`, which is the total shifted right by four.
- R6: With all inputs at 15 for a whole run, `sumOut` reaches 240 and `avgOut` reaches 15. `sumOut` never exceeds 240.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; starts a new run |
| opA | input | 4 | First unsigned operand |
| opB | input | 4 | Second unsigned operand |
| opC | input | 4 | Third unsigned operand |
| opD | input | 4 | Fourth unsigned operand |
| sumOut | output | 8 | Running total |
| avgOut | output | 4 | Total shifted right by four |
| doneOut | output | 1 | One-cycle flag after the fourth accumulation |

## Verification
Two pairs of events can fall on the same edge.

The first pair is the fourth accumulation and the rise of the completion flag. Every run checks both on that edge. The total must include the last operands and `doneOut` must rise, with neither one a cycle late.

The second pair is reset and an accumulation. The bench raises `rst` in the middle of a run and also on the exact edge of the fourth pass. In both cases the total must read zero and `doneOut` must stay low afterwards.

A behavioural model built on integers judges every cycle. It covers random operand sequences and input changes after completion.

// File: rtl/accum_averager_pkg.sv
package accum_averager_pkg;

  // Strobes from the control unit to the datapath, one cycle each
  typedef struct packed {
    logic clearAcc;   // zero the total
    logic loadAcc;    // take the reduced five-operand sum
    logic lastPass;   // this load is the final one of the run
  } ctrlStrobes_t;

endpackage

// File: rtl/csa_stage.sv
// One 3:2 carry-save stage: three vectors in, sum and carry vectors out.
module csa_stage #(
  parameter int W = 8
) (
  input  logic [W-1:0] xIn,
  input  logic [W-1:0] yIn,
  input  logic [W-1:0] zIn,
  output logic [W-1:0] sumVec,
  output logic [W-1:0] carryVec
);
  logic [W-1:0] majority;

  always_comb begin
    sumVec   = xIn ^ yIn ^ zIn;
    majority = (xIn & yIn) | (xIn & zIn) | (yIn & zIn);
    carryVec = {majority[W-2:0], 1'b0};
  end
endmodule

// File: rtl/accum_averager_ctrl.sv
module accum_averager_ctrl
  import accum_averager_pkg::*;
#(
  parameter int PASSES = 4
) (
  input  logic         clk,
  input  logic         rst,
  output ctrlStrobes_t strobes,
  output logic         doneQ
);
  localparam int CNT_W = (PASSES > 1) ? $clog2(PASSES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PASSES - 1);

  logic [CNT_W-1:0] passCnt;
  logic             finishedQ;

  always_comb begin
    strobes.clearAcc = rst;
    strobes.loadAcc  = !rst && !finishedQ;
    strobes.lastPass = !rst && !finishedQ && (passCnt == LAST_CNT);
  end

  always_ff @(posedge clk) begin
    if (strobes.clearAcc) begin
      passCnt   <= '0;
      finishedQ <= 1'b0;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= strobes.lastPass;
      if (strobes.lastPass) begin
        finishedQ <= 1'b1;
      end else if (strobes.loadAcc) begin
        passCnt <= passCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/accum_averager_dp.sv
module accum_averager_dp
  import accum_averager_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int IN_W   = 4,
  parameter int SUM_W  = 8
) (
  input  logic                        clk,
  input  ctrlStrobes_t                strobes,
  input  logic [NUM_IN-1:0][IN_W-1:0] inVec,
  output logic [SUM_W-1:0]            accQ
);
  localparam int NUM_OPS = NUM_IN + 1;   // inputs plus feedback
  localparam int LEVELS  = NUM_OPS - 2;  // 3:2 stages in the chain
  localparam int PAD_W   = SUM_W - IN_W;

  logic [SUM_W-1:0] opsExt [NUM_OPS];
  logic [SUM_W-1:0] redSum [LEVELS+1];
  logic [SUM_W-1:0] redCar [LEVELS+1];
  logic [SUM_W-1:0] cpaOut;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_IN; gi++) begin : g_ext
      assign opsExt[gi] = {{PAD_W{1'b0}}, inVec[gi]};
    end
  endgenerate
  assign opsExt[NUM_IN] = accQ;

  assign redSum[0] = opsExt[0];
  assign redCar[0] = opsExt[1];

  generate
    for (gi = 0; gi < LEVELS; gi++) begin : g_lvl
      csa_stage #(.W(SUM_W)) csa_i (
        .xIn     (redSum[gi]),
        .yIn     (redCar[gi]),
        .zIn     (opsExt[gi+2]),
        .sumVec  (redSum[gi+1]),
        .carryVec(redCar[gi+1])
      );
    end
  endgenerate

  assign cpaOut = redSum[LEVELS] + redCar[LEVELS];

  always_ff @(posedge clk) begin
    if (strobes.clearAcc) begin
      accQ <= '0;
    end else if (strobes.loadAcc) begin
      accQ <= cpaOut;
    end
  end
endmodule

// File: rtl/accum_averager.sv
module accum_averager
  import accum_averager_pkg::*;
#(
  parameter int IN_W   = 4,
  parameter int SUM_W  = 8,
  parameter int PASSES = 4,
  parameter int SHIFT  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [IN_W-1:0]         opA,
  input  logic [IN_W-1:0]         opB,
  input  logic [IN_W-1:0]         opC,
  input  logic [IN_W-1:0]         opD,
  output logic [SUM_W-1:0]        sumOut,
  output logic [SUM_W-SHIFT-1:0]  avgOut,
  output logic                    doneOut
);
  localparam int NUM_IN = 4;
  localparam int AVG_W  = SUM_W - SHIFT;

  ctrlStrobes_t                strobes;
  logic [NUM_IN-1:0][IN_W-1:0] inVec;
  logic [SUM_W-1:0]            accQ;

  assign inVec = {opD, opC, opB, opA};

  accum_averager_ctrl #(.PASSES(PASSES)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .doneQ  (doneOut)
  );

  accum_averager_dp #(.NUM_IN(NUM_IN), .IN_W(IN_W), .SUM_W(SUM_W)) dp_i (
    .clk    (clk),
    .strobes(strobes),
    .inVec  (inVec),
    .accQ   (accQ)
  );

  assign sumOut = accQ;
  assign avgOut = accQ[SHIFT +: AVG_W];
endmodule

// File: rtl/accum_averager_chk.sv
module accum_averager_chk #(
  parameter int IN_W   = 4,
  parameter int SUM_W  = 8,
  parameter int PASSES = 4,
  parameter int SHIFT  = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [IN_W-1:0]        opA,
  input logic [IN_W-1:0]        opB,
  input logic [IN_W-1:0]        opC,
  input logic [IN_W-1:0]        opD,
  input logic [SUM_W-1:0]       sumOut,
  input logic [SUM_W-SHIFT-1:0] avgOut,
  input logic                   doneOut
);
  localparam int MAX_SUM = PASSES * 4 * ((1 << IN_W) - 1);

  int               seenPasses;
  logic [SUM_W-1:0] opsSum;

  assign opsSum = SUM_W'(opA) + SUM_W'(opB) + SUM_W'(opC) + SUM_W'(opD);

  always_ff @(posedge clk) begin
    if (rst) seenPasses <= 0;
    else if (seenPasses < PASSES) seenPasses <= seenPasses + 1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sumOut == '0 && !doneOut));

  // R2
  accumulate_step_chk: assert property (@(posedge clk) disable iff (rst)
    (seenPasses < PASSES) |=> (sumOut == SUM_W'($past(sumOut) + $past(opsSum))));

  // R3
  hold_after_run_chk: assert property (@(posedge clk) disable iff (rst)
    (seenPasses == PASSES) |=> $stable(sumOut));

  // R4
  done_on_last_chk: assert property (@(posedge clk) disable iff (rst)
    (seenPasses == PASSES - 1) |=> doneOut);

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    doneOut |=> !doneOut);

  // R6
  sum_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(sumOut) <= MAX_SUM));
endmodule

bind accum_averager accum_averager_chk #(
  .IN_W(IN_W), .SUM_W(SUM_W), .PASSES(PASSES), .SHIFT(SHIFT)
) chk_i (
  .clk(clk), .rst(rst), .opA(opA), .opB(opB), .opC(opC), .opD(opD),
  .sumOut(sumOut), .avgOut(avgOut), .doneOut(doneOut)
);

// File: tb/accum_averager_tb_top.sv
module accum_averager_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] opA = '0, opB = '0, opC = '0, opD = '0;
  logic [7:0] sumOut;
  logic [3:0] avgOut;
  logic       doneOut;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // reference model state
  int refSum  = 0;
  int refPass = 0;
  bit refDone = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  accum_averager dut_i (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .opC(opC), .opD(opD),
    .sumOut(sumOut), .avgOut(avgOut), .doneOut(doneOut)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, actual, expected, $time);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(bit r, int a, int b, int c, int d);
    string sumTag;
    rst = r; opA = 4'(a); opB = 4'(b); opC = 4'(c); opD = 4'(d);
    @(posedge clk);
    if (r) begin
      refSum = 0; refPass = 0; refDone = 1'b0; sumTag = "R1";
    end else if (refPass < 4) begin
      refSum = (refSum + a + b + c + d) % 256;
      refPass++;
      refDone = (refPass == 4);
      sumTag = "R2";
    end else begin
      refDone = 1'b0; sumTag = "R3";
    end
    @(negedge clk);
    check({sumTag, " sum"}, int'(sumOut), refSum);
    check("R4 done", int'(doneOut), int'(refDone));
    check("R5 average", int'(avgOut), refSum / 16);
  endtask

  task automatic randStep(bit r);
    step(r, $urandom_range(0, 15), $urandom_range(0, 15),
            $urandom_range(0, 15), $urandom_range(0, 15));
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1 reset state, with busy inputs during reset
    step(1'b1, 15, 15, 15, 15);
    step(1'b1, 7, 3, 9, 1);

    // R2 fixed run, R4 done on the fourth pass
    step(1'b0, 1, 2, 3, 4);
    step(1'b0, 0, 0, 0, 0);
    step(1'b0, 15, 0, 8, 1);
    step(1'b0, 5, 5, 5, 5);
    // R3 held, inputs ignored
    for (int i = 0; i < 6; i++) randStep(1'b0);

    // R6 all-max run reaches 240 / 15
    step(1'b1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(1'b0, 15, 15, 15, 15);
    check("R6 max sum", int'(sumOut), 240);
    check("R6 max average", int'(avgOut), 15);
    step(1'b0, 15, 15, 15, 15);
    check("R6 max held", int'(sumOut), 240);

    // R1 reset in mid-run
    step(1'b1, 0, 0, 0, 0);
    randStep(1'b0); randStep(1'b0);
    step(1'b1, 9, 9, 9, 9);
    for (int i = 0; i < 6; i++) randStep(1'b0);

    // R1 reset on the edge of the fourth pass: no done
    step(1'b1, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) randStep(1'b0);
    step(1'b1, 15, 15, 15, 15);
    check("R1 no done after reset", int'(doneOut), 0);
    for (int i = 0; i < 5; i++) randStep(1'b0);

    // random runs with random reset points
    for (int run = 0; run < 300; run++) begin
      step(1'b1, 0, 0, 0, 0);
      for (int i = 0; i < 4 + $urandom_range(0, 4); i++)
        randStep($urandom_range(0, 19) == 0);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule